// File: doc/BRIEF.md
# Triggered Sample Clock Timing Engine

This block produces the conversion strobe for a multichannel acquisition. One of two sources paces it. The first is an internal period counter that divides the block clock, which serves as the timebase. The second is a free-running external sample clock, whose rising edges are detected in the block clock domain. Software arms the engine. The engine then waits for an edge of the start trigger, with a selectable polarity. After the trigger it emits either a counted burst or an unbounded stream of samples. In retrigger mode, every accepted start edge launches one burst, and the engine then re-arms by itself.

A pause input is level sensitive and has a programmable active level. With the internal source, pause freezes the delay and period counters, and they resume from where they stopped. With the external source, pause discards the edges that arrive while it is active. Each sample produces a one-cycle strobe and an active-high exported pulse. Both begin in the same cycle. A done flag reports that a finite, non-retriggered burst has completed.

Top module: `tse_engine`

## Requirements
- R1: With the internal source, samples inside a burst are spaced by exactly max(cfg_divide, 2) clock cycles, so a divide value of 0 or 1 behaves as 2.
- R2: After reset, or while idle, done, or armed without a start edge, the strobe stays low. `arm` is accepted only in idle or done, and it moves the engine to waiting for a start edge.
- R3: While waiting, the engine accepts a start edge when `start_trig` goes 0 to 1 (cfg_trig_fall = 0) or 1 to 0 (cfg_trig_fall = 1). An edge of the opposite polarity does nothing.
- R4: With the internal source, the first strobe appears D clock cycles after the clock edge that samples the start edge. D is cfg_delay, and a cfg_delay of 0 selects the parameter DLY_DEFAULT (default 2).
- R5: In finite mode (cfg_continuous = 0), exactly cfg_count strobes are produced, with a count of 0 acting as 1. `done` goes high in the cycle of the last strobe and stays high until `arm` or `stop`.
- R6: With cfg_retrig = 1, each accepted start edge launches one finite burst. Start edges during a burst are ignored. The engine returns to waiting after the last strobe and never raises `done`.
- R7: With the internal source, every clock in which pause is active (cfg_pause_en = 1 and pause_trig == cfg_pause_high) holds the delay and period counters. Each such cycle postpones every later strobe by one cycle, and no strobe is lost.
- R8: With the external source (cfg_ext_src = 1), a strobe follows each rising edge of `ext_clk` seen after the start edge. Edges seen while pause is active are dropped, not deferred. No start delay applies to this source.
- R9: `smp_export` goes high in the same cycle as `smp_strobe` and stays high for EXP_W cycles.
- R10: In continuous mode, cfg_count is ignored, and strobes continue until `stop`.
- R11: `stop` sampled high returns the engine to idle at that same clock edge. No strobe follows it, and `done` is cleared.
- R12: A new cfg_divide written while samples are running takes effect at the next period boundary. The period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase and block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_src | input | 1 | 1 selects external sample clock, 0 the internal divider |
| cfg_trig_fall | input | 1 | Start edge polarity: 0 rising, 1 falling |
| cfg_retrig | input | 1 | Re-arm after each finite burst |
| cfg_continuous | input | 1 | Ignore count and run until stop |
| cfg_pause_en | input | 1 | Enable the pause input |
| cfg_pause_high | input | 1 | Active level of pause_trig |
| cfg_divide | input | DIV_W | Internal sample period in clock cycles |
| cfg_delay | input | DLY_W | Start-to-first-sample delay, 0 = default |
| cfg_count | input | CNT_W | Samples per finite burst |
| arm | input | 1 | Software arm pulse |
| stop | input | 1 | Software stop |
| start_trig | input | 1 | Start trigger line |
| pause_trig | input | 1 | Pause trigger line |
| ext_clk | input | 1 | External free-running sample clock |
| smp_strobe | output | 1 | One-cycle conversion strobe |
| smp_export | output | 1 | Exported active-high sample pulse |
| done | output | 1 | Finite burst complete |

## Verification
The bench triggers bursts with a start delay of zero, which must select the default delay. A design that counted the raw value would fire one cycle after the trigger. It pauses in mid-period with the internal source, where a design that restarted the period instead of holding it would shift every later sample. Under the external source, a design that queued masked edges would emit a strobe straight after the pause ends. The bench also sends a start edge during a retriggered burst, which a careless design would use to restart the burst and so change the sample total. It changes the divide value in mid-run, where a design that reloaded at once would cut the current period short. It issues a stop, after which any leftover strobe or a done flag that stays set would show.

// File: rtl/tse_pkg.sv
package tse_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_DELAY = 3'd2,
      ST_RUN   = 3'd3,
      ST_DONE  = 3'd4
   } tse_state_t;

   localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/tse_edge_det.sv
module tse_edge_det #(
   parameter int unsigned SYNC = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic sig,
   input  logic fall_sel,
   output logic edge_seen
);
   initial begin
      if (SYNC > 3) $error("tse_edge_det: SYNC must be 0..3");
   end

   logic s;
   logic prev_q;

   generate
      if (SYNC == 0) begin : g_direct
         assign s = sig;
      end else if (SYNC == 1) begin : g_one
         logic sh_q;
         always_ff @(posedge clk) begin
            if (rst) sh_q <= 1'b0;
            else     sh_q <= sig;
         end
         assign s = sh_q;
      end else begin : g_chain
         logic [SYNC-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[SYNC-2:0], sig};
         end
         assign s = sh_q[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= s;
   end

   assign edge_seen = fall_sel ? (prev_q & ~s) : (~prev_q & s);
endmodule

// File: rtl/tse_downcnt.sv
module tse_downcnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] val,
   output logic         at_one
);
   initial begin
      if (W < 1) $error("tse_downcnt: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                       cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
   end

   assign val    = cnt_q;
   assign at_one = (cnt_q <= W'(1));
endmodule

// File: rtl/tse_stretch.sv
module tse_stretch #(
   parameter int unsigned EXP_W = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse
);
   localparam int unsigned CW = (EXP_W > 1) ? $clog2(EXP_W) : 1;

   initial begin
      if (EXP_W < 1) $error("tse_stretch: EXP_W must be at least 1");
   end

   logic          pulse_q;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse_q <= 1'b0;
         left_q  <= '0;
      end else if (fire) begin
         pulse_q <= 1'b1;
         left_q  <= CW'(EXP_W - 1);
      end else if (left_q != '0) begin
         pulse_q <= 1'b1;
         left_q  <= left_q - CW'(1);
      end else begin
         pulse_q <= 1'b0;
      end
   end

   assign pulse = pulse_q;

   assert_export_follows_R9: assert property (@(posedge clk) disable iff (rst)
      fire |=> pulse);
endmodule

// File: rtl/tse_engine.sv
module tse_engine
   import tse_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned DLY_W       = 16,
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned DLY_DEFAULT = 2,
   parameter int unsigned EXP_W       = 1,
   parameter int unsigned EXT_SYNC    = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_ext_src,
   input  logic             cfg_trig_fall,
   input  logic             cfg_retrig,
   input  logic             cfg_continuous,
   input  logic             cfg_pause_en,
   input  logic             cfg_pause_high,
   input  logic [DIV_W-1:0] cfg_divide,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             arm,
   input  logic             stop,
   input  logic             start_trig,
   input  logic             pause_trig,
   input  logic             ext_clk,
   output logic             smp_strobe,
   output logic             smp_export,
   output logic             done
);
   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(MIN_PERIOD);
   localparam logic [DLY_W-1:0] DLY_DEF = DLY_W'(DLY_DEFAULT);

   initial begin
      if (DIV_W < 2)        $error("tse_engine: DIV_W must be at least 2");
      if (DLY_W < 1)        $error("tse_engine: DLY_W must be at least 1");
      if (CNT_W < 1)        $error("tse_engine: CNT_W must be at least 1");
      if (DLY_DEFAULT < 1)  $error("tse_engine: DLY_DEFAULT must be at least 1");
      if (DLY_DEFAULT >= (64'd1 << DLY_W))
                            $error("tse_engine: DLY_DEFAULT does not fit DLY_W");
      if (EXP_W < 1)        $error("tse_engine: EXP_W must be at least 1");
   end

   tse_state_t st_q, st_d;

   logic start_edge, ext_rise;
   logic pause_act, running;
   logic fire, fire_int, fire_ext, last;
   logic strobe_q;

   logic [DIV_W-1:0] div_eff;
   logic [DLY_W-1:0] dly_eff;

   logic             dly_load, dly_dec, dly_one;
   logic [DLY_W-1:0] dly_val;
   logic             per_load, per_dec, per_one;
   logic [DIV_W-1:0] per_val;
   logic             rem_load, rem_one;
   logic [CNT_W-1:0] rem_val;

   tse_edge_det #(.SYNC(0)) u_start_edge (
      .clk       (clk),
      .rst       (rst),
      .sig       (start_trig),
      .fall_sel  (cfg_trig_fall),
      .edge_seen (start_edge)
   );

   tse_edge_det #(.SYNC(EXT_SYNC)) u_ext_edge (
      .clk       (clk),
      .rst       (rst),
      .sig       (ext_clk),
      .fall_sel  (1'b0),
      .edge_seen (ext_rise)
   );

   assign pause_act = cfg_pause_en && (pause_trig == cfg_pause_high);
   assign running   = ~pause_act;
   assign div_eff   = (cfg_divide < DIV_MIN) ? DIV_MIN : cfg_divide;
   assign dly_eff   = (cfg_delay == '0) ? DLY_DEF : cfg_delay;

   assign fire_int = running && !cfg_ext_src &&
                     (((st_q == ST_DELAY) && dly_one) ||
                      ((st_q == ST_RUN)   && per_one));
   assign fire_ext = running && cfg_ext_src && (st_q == ST_RUN) && ext_rise;
   assign fire     = !stop && (fire_int || fire_ext);
   assign last     = fire && !cfg_continuous && rem_one;

   assign dly_load = (st_q == ST_WAIT) && start_edge;
   assign dly_dec  = (st_q == ST_DELAY) && running;
   assign per_load = fire;
   assign per_dec  = (st_q == ST_RUN) && !cfg_ext_src && running;
   assign rem_load = (st_q == ST_WAIT) && start_edge;

   tse_downcnt #(.W(DLY_W)) u_delay_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (dly_load),
      .load_val (dly_eff),
      .dec      (dly_dec),
      .val      (dly_val),
      .at_one   (dly_one)
   );

   tse_downcnt #(.W(DIV_W)) u_period_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (per_load),
      .load_val (div_eff),
      .dec      (per_dec),
      .val      (per_val),
      .at_one   (per_one)
   );

   tse_downcnt #(.W(CNT_W)) u_remain_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (rem_load),
      .load_val (cfg_count),
      .dec      (fire),
      .val      (rem_val),
      .at_one   (rem_one)
   );

   always_comb begin
      st_d = st_q;
      if (stop) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_DONE: if (arm) st_d = ST_WAIT;
            ST_WAIT:  if (start_edge) st_d = cfg_ext_src ? ST_RUN : ST_DELAY;
            ST_DELAY: if (fire) st_d = ST_RUN;
            ST_RUN:   st_d = ST_RUN;
            default:  st_d = ST_IDLE;
         endcase
         if (last) st_d = cfg_retrig ? ST_WAIT : ST_DONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         strobe_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         strobe_q <= fire;
      end
   end

   tse_stretch #(.EXP_W(EXP_W)) u_export (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire),
      .pulse (smp_export)
   );

   assign smp_strobe = strobe_q;
   assign done       = (st_q == ST_DONE);

   assert_quiet_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE || st_q == ST_WAIT || st_q == ST_DONE) |=> !smp_strobe);

   assert_done_on_last_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> smp_strobe);

   assert_retrig_no_done_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_retrig && (st_q == ST_DELAY || st_q == ST_RUN)) |=> (st_q != ST_DONE));

   assert_pause_holds_period_R7: assert property (@(posedge clk) disable iff (rst)
      (pause_act && st_q == ST_RUN && !cfg_ext_src) |=> $stable(per_val));

   assert_pause_masks_R8: assert property (@(posedge clk) disable iff (rst)
      pause_act |=> !smp_strobe);

   assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (rst)
      stop |=> (st_q == ST_IDLE && !smp_strobe && !done));

   assert_export_with_strobe_R9: assert property (@(posedge clk) disable iff (rst)
      smp_strobe |-> smp_export);

   assert_period_floor_R1: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_RUN && !cfg_ext_src && smp_strobe) |-> (per_val >= DIV_MIN));
endmodule

// File: tb/tse_engine_tb.sv
module tse_engine_tb_top;
   localparam int DIV_W = 16;
   localparam int DLY_W = 16;
   localparam int CNT_W = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_ext_src = 0, cfg_trig_fall = 0, cfg_retrig = 0, cfg_continuous = 0;
   logic cfg_pause_en = 0, cfg_pause_high = 1;
   logic [DIV_W-1:0] cfg_divide = 16'd4;
   logic [DLY_W-1:0] cfg_delay = '0;
   logic [CNT_W-1:0] cfg_count = 24'd1;
   logic arm = 0, stop = 0, start_trig = 0, pause_trig = 0, ext_clk = 0;
   logic smp_strobe, smp_export, done;

   always #10 clk = ~clk;

   tse_engine dut_i (
      .clk(clk), .rst(rst),
      .cfg_ext_src(cfg_ext_src), .cfg_trig_fall(cfg_trig_fall),
      .cfg_retrig(cfg_retrig), .cfg_continuous(cfg_continuous),
      .cfg_pause_en(cfg_pause_en), .cfg_pause_high(cfg_pause_high),
      .cfg_divide(cfg_divide), .cfg_delay(cfg_delay), .cfg_count(cfg_count),
      .arm(arm), .stop(stop), .start_trig(start_trig), .pause_trig(pause_trig),
      .ext_clk(ext_clk),
      .smp_strobe(smp_strobe), .smp_export(smp_export), .done(done)
   );

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;
   int strobes = 0;
   string cur_req = "R2";
   bit ext_run = 0;
   int ext_ph  = 0;

   // behavioural reference: 0 idle, 1 waiting, 2 delaying, 3 sampling, 4 finished
   int  m_mode = 0;
   int  m_left = 0;
   longint m_rem = 0;
   bit  m_trig_prev = 0, m_ext_prev = 0;
   bit  m_strobe = 0, m_done = 0;

   always @(posedge clk) begin
      bit edge_hit, ext_hit, paused, shot;
      int want_div, want_dly;
      cycles++;
      if (rst) begin
         m_mode = 0; m_left = 0; m_rem = 0;
         m_trig_prev = 0; m_ext_prev = 0;
         m_strobe = 0; m_done = 0;
      end else begin
         edge_hit = cfg_trig_fall ? (m_trig_prev && !start_trig) : (!m_trig_prev && start_trig);
         ext_hit  = ext_clk && !m_ext_prev;
         m_trig_prev = start_trig;
         m_ext_prev  = ext_clk;
         paused   = cfg_pause_en && (pause_trig == cfg_pause_high);
         want_div = (cfg_divide < 2) ? 2 : int'(cfg_divide);
         want_dly = (cfg_delay == 0) ? 2 : int'(cfg_delay);
         shot = 0;
         if (stop) m_mode = 0;
         else begin
            case (m_mode)
               0, 4: if (arm) m_mode = 1;
               1: if (edge_hit) begin
                     m_rem = cfg_count;
                     if (cfg_ext_src) m_mode = 3;
                     else begin m_mode = 2; m_left = want_dly; end
                  end
               2, 3: if (!paused) begin
                     if (cfg_ext_src) shot = (m_mode == 3) && ext_hit;
                     else if (m_left <= 1) shot = 1;
                     else m_left--;
                  end
               default: m_mode = 0;
            endcase
            if (shot) begin
               m_left = want_div;
               if (!cfg_continuous && m_rem <= 1) m_mode = cfg_retrig ? 1 : 4;
               else begin m_rem--; m_mode = 3; end
            end
         end
         m_strobe = shot;
         m_done   = (m_mode == 4);
      end
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         vectors++;
         if (smp_strobe) strobes++;
         if (smp_strobe !== m_strobe || smp_export !== m_strobe || done !== m_done) begin
            fails++;
            $display("FAIL %s cycle %0d: strobe/export/done actual %b%b%b expected %b%b%b",
                     cur_req, cycles, smp_strobe, smp_export, done, m_strobe, m_strobe, m_done);
         end
         if (ext_run) begin
            ext_ph++;
            if (ext_ph == 3) begin ext_clk = ~ext_clk; ext_ph = 0; end
         end
      end
   endtask

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic restart();
      stop = 1; tick(1); stop = 0;
      arm = 1;  tick(1); arm = 0;
      strobes = 0;
   endtask

   task automatic pulse_trig();
      start_trig = 1; tick(1); start_trig = 0;
   endtask

   initial begin
      int watch_limit = 100000;
      while (cycles < watch_limit) @(posedge clk);
      fails++;
      $display("FAIL %s watchdog: actual %0d cycles expected < %0d", cur_req, cycles, watch_limit);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      tick(3);
      rst = 0;
      tick(1);
      // R2 reset state
      check("R2 reset strobe", int'(smp_strobe), 0);
      check("R2 reset done", int'(done), 0);

      // R2: armed but no trigger
      cur_req = "R2";
      restart(); tick(20);
      check("R2 no strobe without trigger", strobes, 0);

      // R4 R1 R5: default delay, divide 5, count 4
      cur_req = "R4"; cfg_delay = 0; cfg_divide = 5; cfg_count = 4;
      restart(); pulse_trig(); tick(40);
      check("R5 burst length", strobes, 4);
      check("R5 done held", int'(done), 1);

      // R3: falling edge polarity, count 3, delay 3, divide 4
      cur_req = "R3"; cfg_trig_fall = 1; cfg_count = 3; cfg_delay = 3; cfg_divide = 4;
      restart(); start_trig = 1; tick(10);
      check("R3 rising ignored in falling mode", strobes, 0);
      start_trig = 0; tick(40);
      check("R3 falling edge burst", strobes, 3);
      cfg_trig_fall = 0;

      // R7: pause with internal source
      cur_req = "R7"; cfg_divide = 6; cfg_count = 3; cfg_delay = 1;
      cfg_pause_en = 1; cfg_pause_high = 1;
      restart(); pulse_trig(); tick(4);
      pause_trig = 1; strobes = 0; tick(10);
      check("R7 no strobe while paused", strobes, 0);
      pause_trig = 0; tick(40);
      check("R7 all samples kept", strobes, 2);
      check("R7 done after resume", int'(done), 1);

      // R6: retrigger, edge during burst ignored
      cur_req = "R6"; cfg_retrig = 1; cfg_count = 2; cfg_divide = 3; cfg_delay = 2;
      restart();
      pulse_trig(); tick(1); pulse_trig(); tick(20);
      pulse_trig(); tick(20);
      check("R6 two bursts of two", strobes, 4);
      check("R6 done stays low", int'(done), 0);
      cfg_retrig = 0;

      // R8: external clock with pause masking
      cur_req = "R8"; cfg_ext_src = 1; cfg_count = 200; cfg_pause_high = 0;
      pause_trig = 1;
      restart(); ext_run = 1; pulse_trig(); tick(30);
      pause_trig = 0; strobes = 0; tick(24);
      check("R8 edges masked during pause", strobes, 0);
      pause_trig = 1; tick(30);
      ext_run = 0; cfg_ext_src = 0; cfg_pause_en = 0;

      // R10 R12 R11: continuous, divide change, stop
      cur_req = "R10"; cfg_continuous = 1; cfg_count = 1; cfg_divide = 4; cfg_delay = 0;
      restart(); pulse_trig(); tick(30);
      check("R10 count ignored", int'(strobes >= 5), 1);
      cur_req = "R12"; cfg_divide = 7; tick(30);
      cur_req = "R11"; stop = 1; tick(1); stop = 0; strobes = 0; tick(20);
      check("R11 silent after stop", strobes, 0);
      check("R11 done clear", int'(done), 0);

      // R1: divide below two clamps
      cur_req = "R1"; cfg_divide = 1;
      restart(); pulse_trig(); tick(21);
      check("R1 clamped spacing", strobes, 10);
      stop = 1; tick(1); stop = 0;
      cfg_divide = 0; restart(); pulse_trig(); tick(21);
      check("R1 zero divide", strobes, 10);
      stop = 1; tick(2); stop = 0;

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule